// File: doc/BRIEF.md
# Audio Serial Port Run-State Controller

This block keeps the run state of a full-duplex audio serial port: the port mode, the global active flag, and the DMA-active, DMA-pause and channel-pause flags for each direction. Separate start and stop pulses for transmit and receive update the mode and the flags as one unit. Enabling a direction merges it into the current mode, and disabling one splits it out. The port-wide active flag drops only when the last running direction stops.

A start request runs a short sequence. First the direction's FIFO flush strobe pulses for one cycle. Then the controller waits for the serial clock phase when the port is a clock slave. Only after that are the flags committed. A stop request takes effect on the next clock edge. It does not flush the FIFO, and it cancels any start still in progress. The block also reports FIFO empty and full from the FIFO fill levels and passes the left/right phase through. A timeout during phase wait and an illegal direct mode write each raise a sticky error flag.

Top module: `audio_port_ctrl`

## Requirements
- R1: After reset, mode_o is 3'b000 (off), port_act_o and both DMA-active flags are 0, and all four pause flags are 1. Both error flags and both flush strobes are 0.
- R2: Committing a transmit start sets tx_dma_act_o and port_act_o and clears tx_dma_pause_o and tx_ch_pause_o. Mode bit 0 marks transmit and bit 1 marks receive. The mode moves from off (000) to transmit-only (001), from receive-only (010) to duplex (011), and is unchanged from 001 or 011.
- R3: A transmit stop sets both transmit pause flags and clears tx_dma_act_o. Duplex becomes receive-only. Transmit-only becomes off and clears port_act_o. From off or receive-only, the mode and port_act_o are unchanged.
- R4: Committing a receive start mirrors R2: it sets rx_dma_act_o and port_act_o and clears both receive pause flags. Off becomes 010, transmit-only becomes duplex, and 010 or 011 is unchanged.
- R5: A receive stop mirrors R3: duplex becomes transmit-only, and receive-only becomes off and clears port_act_o.
- R6: In master mode, a start pulse sampled at clock edge N drives that direction's flush strobe high for exactly the cycle after edge N. The flags are committed at edge N+2.
- R7: In slave mode, the commit waits for lr_phase_i high. If lr_phase_i stays low for lr_timeout_i+1 wait cycles, nothing is committed and err_sync_o sets and stays set.
- R8: A mode write with mode_wdata_i[2]=0 loads the mode field directly. A write with mode_wdata_i[2]=1 leaves the mode unchanged and sets err_mode_o, which stays set.
- R9: A stop pulse in the same cycle as a start pulse for the same direction wins: there is no flush and no commit. A stop also cancels a start that is still pending.
- R10: A FIFO empty flag is 1 when that direction's level is 0. A FIFO full flag is 1 when the level equals FIFO_DEPTH. lr_phase_o follows lr_phase_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slave_mode_i | input | 1 | Port is a serial clock slave; starts wait for the phase |
| lr_phase_i | input | 1 | Left/right phase indicator from the serializer |
| lr_timeout_i | input | TMO_W | Phase-wait timeout in cycles |
| tx_start_i | input | 1 | Transmit start request pulse |
| tx_stop_i | input | 1 | Transmit stop request pulse |
| rx_start_i | input | 1 | Receive start request pulse |
| rx_stop_i | input | 1 | Receive stop request pulse |
| mode_wr_i | input | 1 | Direct mode write strobe |
| mode_wdata_i | input | 3 | Mode value for a direct write |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| mode_o | output | 3 | Current mode (bit0 transmit, bit1 receive) |
| port_act_o | output | 1 | Port-wide active flag |
| tx_dma_act_o | output | 1 | Transmit DMA active |
| tx_dma_pause_o | output | 1 | Transmit DMA pause |
| tx_ch_pause_o | output | 1 | Transmit channel pause |
| rx_dma_act_o | output | 1 | Receive DMA active |
| rx_dma_pause_o | output | 1 | Receive DMA pause |
| rx_ch_pause_o | output | 1 | Receive channel pause |
| tx_flush_o | output | 1 | Transmit FIFO flush strobe |
| rx_flush_o | output | 1 | Receive FIFO flush strobe |
| tx_fifo_empty_o | output | 1 | Transmit FIFO empty |
| tx_fifo_full_o | output | 1 | Transmit FIFO full |
| rx_fifo_empty_o | output | 1 | Receive FIFO empty |
| rx_fifo_full_o | output | 1 | Receive FIFO full |
| lr_phase_o | output | 1 | Current left/right phase |
| err_sync_o | output | 1 | Sticky phase-wait timeout error |
| err_mode_o | output | 1 | Sticky illegal mode write error |

## Verification
The bench builds the block with FIFO_DEPTH=8 and TMO_W=4, so the full flag is reached with a small level value. The phase-wait timeout is driven through lr_timeout_i, and a value of 6 makes both outcomes quick to reach: the phase arriving partway through the wait, and the timeout expiring. A table walks every merge and split of the mode, including stops of a direction that is not running and a rejected mode write. Directed tests then pin the flush and commit cycles, the priority of a stop over a start, and the cancelling of a pending start.

// File: rtl/audio_port_pkg.sv
package audio_port_pkg;
  localparam logic [2:0] MODE_OFF = 3'b000;
  localparam logic [2:0] MODE_TX  = 3'b001;
  localparam logic [2:0] MODE_RX  = 3'b010;
  localparam logic [2:0] MODE_DUP = 3'b011;

  typedef struct packed {
    logic act;
    logic dpause;
    logic cpause;
  } dir_flags_t;

  // dir[0] transmit, dir[1] receive; mode bit d marks direction d
  typedef struct packed {
    logic [2:0]       mode;
    logic             port_act;
    dir_flags_t [1:0] dir;
  } run_st_t;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_FLUSH, SEQ_WAIT} seq_e;

  function automatic run_st_t dir_on(run_st_t s, logic d);
    run_st_t r;
    r = s;
    r.port_act      = 1'b1;
    r.dir[d].act    = 1'b1;
    r.dir[d].dpause = 1'b0;
    r.dir[d].cpause = 1'b0;
    r.mode[d]       = 1'b1;
    return r;
  endfunction

  function automatic run_st_t dir_off(run_st_t s, logic d);
    run_st_t r;
    logic [2:0] own;
    r   = s;
    own = d ? MODE_RX : MODE_TX;
    r.dir[d].act    = 1'b0;
    r.dir[d].dpause = 1'b1;
    r.dir[d].cpause = 1'b1;
    r.mode[d]       = 1'b0;
    // last running direction drops the port
    if (s.mode == own) r.port_act = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/dir_start_seq.sv
module dir_start_seq
  import audio_port_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             slave_i,
  input  logic             lr_i,
  input  logic [TMO_W-1:0] timeout_i,
  output logic             flush_o,
  output logic             go_o,
  output logic             tmo_o
);
  seq_e             st_q;
  logic [TMO_W-1:0] cnt_q;
  logic             ready;

  assign ready   = !slave_i || lr_i;
  assign flush_o = (st_q == SEQ_FLUSH);
  assign go_o    = (st_q == SEQ_WAIT) && ready && !stop_i;
  assign tmo_o   = (st_q == SEQ_WAIT) && !ready && !stop_i && (cnt_q == timeout_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
    end else if (stop_i) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE:  if (start_i) st_q <= SEQ_FLUSH;
        SEQ_FLUSH: begin
          st_q  <= SEQ_WAIT;
          cnt_q <= '0;
        end
        SEQ_WAIT: begin
          if (go_o || tmo_o) st_q <= SEQ_IDLE;
          else               cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/run_state_core.sv
module run_state_core
  import audio_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] go_i,
  input  logic [1:0] stop_i,
  input  logic       tmo_i,
  input  logic       mode_wr_i,
  input  logic [2:0] mode_wdata_i,
  output run_st_t    st_o,
  output logic       err_sync_o,
  output logic       err_mode_o
);
  run_st_t st_q, st_d;
  logic    bad_wr;

  assign bad_wr = mode_wr_i && mode_wdata_i[2];

  always_comb begin
    st_d = st_q;
    if (mode_wr_i && !mode_wdata_i[2]) st_d.mode = mode_wdata_i;
    for (int d = 0; d < 2; d++) begin
      if (stop_i[d])    st_d = dir_off(st_d, d[0]);
      else if (go_i[d]) st_d = dir_on(st_d, d[0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q.mode     <= MODE_OFF;
      st_q.port_act <= 1'b0;
      st_q.dir      <= {2{3'b011}};
      err_sync_o    <= 1'b0;
      err_mode_o    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (tmo_i)  err_sync_o <= 1'b1;
      if (bad_wr) err_mode_o <= 1'b1;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/fifo_level_flags.sv
module fifo_level_flags #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] level_i,
  output logic             empty_o,
  output logic             full_o
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  assign empty_o = (level_i == '0);
  assign full_o  = (level_i >= FULL_LVL);
endmodule

// File: rtl/audio_port_ctrl.sv
module audio_port_ctrl
  import audio_port_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int TMO_W      = 8,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slave_mode_i,
  input  logic             lr_phase_i,
  input  logic [TMO_W-1:0] lr_timeout_i,
  input  logic             tx_start_i,
  input  logic             tx_stop_i,
  input  logic             rx_start_i,
  input  logic             rx_stop_i,
  input  logic             mode_wr_i,
  input  logic [2:0]       mode_wdata_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  output logic [2:0]       mode_o,
  output logic             port_act_o,
  output logic             tx_dma_act_o,
  output logic             tx_dma_pause_o,
  output logic             tx_ch_pause_o,
  output logic             rx_dma_act_o,
  output logic             rx_dma_pause_o,
  output logic             rx_ch_pause_o,
  output logic             tx_flush_o,
  output logic             rx_flush_o,
  output logic             tx_fifo_empty_o,
  output logic             tx_fifo_full_o,
  output logic             rx_fifo_empty_o,
  output logic             rx_fifo_full_o,
  output logic             lr_phase_o,
  output logic             err_sync_o,
  output logic             err_mode_o
);
  localparam int NDIR = 2;

  logic [NDIR-1:0] dir_start, dir_stop, dir_go, dir_tmo, dir_flush;
  logic [NDIR-1:0] fifo_empty, fifo_full;
  logic [NDIR-1:0][LVL_W-1:0] dir_level;
  run_st_t st;

  assign dir_start = {rx_start_i, tx_start_i};
  assign dir_stop  = {rx_stop_i, tx_stop_i};
  assign dir_level = {rx_level_i, tx_level_i};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    dir_start_seq #(.TMO_W(TMO_W)) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (dir_start[d]),
      .stop_i    (dir_stop[d]),
      .slave_i   (slave_mode_i),
      .lr_i      (lr_phase_i),
      .timeout_i (lr_timeout_i),
      .flush_o   (dir_flush[d]),
      .go_o      (dir_go[d]),
      .tmo_o     (dir_tmo[d])
    );

    fifo_level_flags #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_lvl (
      .level_i (dir_level[d]),
      .empty_o (fifo_empty[d]),
      .full_o  (fifo_full[d])
    );
  end

  run_state_core u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (dir_go),
    .stop_i       (dir_stop),
    .tmo_i        (|dir_tmo),
    .mode_wr_i    (mode_wr_i),
    .mode_wdata_i (mode_wdata_i),
    .st_o         (st),
    .err_sync_o   (err_sync_o),
    .err_mode_o   (err_mode_o)
  );

  assign mode_o          = st.mode;
  assign port_act_o      = st.port_act;
  assign tx_dma_act_o    = st.dir[0].act;
  assign tx_dma_pause_o  = st.dir[0].dpause;
  assign tx_ch_pause_o   = st.dir[0].cpause;
  assign rx_dma_act_o    = st.dir[1].act;
  assign rx_dma_pause_o  = st.dir[1].dpause;
  assign rx_ch_pause_o   = st.dir[1].cpause;
  assign tx_flush_o      = dir_flush[0];
  assign rx_flush_o      = dir_flush[1];
  assign tx_fifo_empty_o = fifo_empty[0];
  assign tx_fifo_full_o  = fifo_full[0];
  assign rx_fifo_empty_o = fifo_empty[1];
  assign rx_fifo_full_o  = fifo_full[1];
  assign lr_phase_o      = lr_phase_i;
endmodule

// File: rtl/audio_port_ctrl_chk.sv
module audio_port_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_stop_i,
  input logic       rx_stop_i,
  input logic       mode_wr_i,
  input logic [2:0] mode_wdata_i,
  input logic [1:0] go_i,
  input logic [2:0] mode_o,
  input logic       port_act_o,
  input logic       tx_dma_act_o,
  input logic       tx_dma_pause_o,
  input logic       tx_ch_pause_o,
  input logic       rx_dma_act_o,
  input logic       rx_dma_pause_o,
  input logic       rx_ch_pause_o,
  input logic       tx_flush_o,
  input logic       rx_flush_o,
  input logic       err_sync_o,
  input logic       err_mode_o
);
  AST_TX_GO_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i[0] && !tx_stop_i |=> tx_dma_act_o && port_act_o && !tx_dma_pause_o); // R2
  AST_TX_STOP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_stop_i |=> tx_dma_pause_o && tx_ch_pause_o && !tx_dma_act_o); // R3
  AST_RX_GO_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i[1] && !rx_stop_i |=> rx_dma_act_o && port_act_o && !rx_ch_pause_o); // R4
  AST_RX_STOP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_stop_i |=> rx_dma_pause_o && rx_ch_pause_o && !rx_dma_act_o); // R5
  AST_TX_FLUSH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_flush_o |=> !tx_flush_o); // R6
  AST_RX_FLUSH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_o |=> !rx_flush_o); // R6
  AST_SYNC_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_sync_o |=> err_sync_o); // R7
  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o[2]); // R8
  AST_BAD_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i && mode_wdata_i[2] && go_i == 2'b00 && !tx_stop_i && !rx_stop_i
    |=> $stable(mode_o) && err_mode_o); // R8
  AST_STOP_NO_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_stop_i |=> !tx_flush_o); // R9
  AST_RX_STOP_NO_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_stop_i |=> !rx_flush_o); // R9
endmodule

bind audio_port_ctrl audio_port_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tx_stop_i      (tx_stop_i),
  .rx_stop_i      (rx_stop_i),
  .mode_wr_i      (mode_wr_i),
  .mode_wdata_i   (mode_wdata_i),
  .go_i           (dir_go),
  .mode_o         (mode_o),
  .port_act_o     (port_act_o),
  .tx_dma_act_o   (tx_dma_act_o),
  .tx_dma_pause_o (tx_dma_pause_o),
  .tx_ch_pause_o  (tx_ch_pause_o),
  .rx_dma_act_o   (rx_dma_act_o),
  .rx_dma_pause_o (rx_dma_pause_o),
  .rx_ch_pause_o  (rx_ch_pause_o),
  .tx_flush_o     (tx_flush_o),
  .rx_flush_o     (rx_flush_o),
  .err_sync_o     (err_sync_o),
  .err_mode_o     (err_mode_o)
);

// File: tb/audio_port_ctrl_tb.sv
`timescale 1ns/1ps
module audio_port_ctrl_tb;
  localparam int DEPTH = 8;
  localparam int TW    = 4;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic slave = 1'b0, lr = 1'b0;
  logic [TW-1:0] tmo = 4'd6;
  logic tx_start = 0, tx_stop = 0, rx_start = 0, rx_stop = 0, mwr = 0;
  logic [2:0] mwd = 3'b000;
  logic [LW-1:0] tx_lvl = '0, rx_lvl = '0;
  logic [2:0] mode;
  logic port_act, txa, txdp, txcp, rxa, rxdp, rxcp, txf, rxf;
  logic txe, txfl, rxe, rxfl, lro, esync, emode;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  audio_port_ctrl #(.FIFO_DEPTH(DEPTH), .TMO_W(TW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .slave_mode_i(slave), .lr_phase_i(lr),
    .lr_timeout_i(tmo), .tx_start_i(tx_start), .tx_stop_i(tx_stop),
    .rx_start_i(rx_start), .rx_stop_i(rx_stop), .mode_wr_i(mwr),
    .mode_wdata_i(mwd), .tx_level_i(tx_lvl), .rx_level_i(rx_lvl),
    .mode_o(mode), .port_act_o(port_act), .tx_dma_act_o(txa),
    .tx_dma_pause_o(txdp), .tx_ch_pause_o(txcp), .rx_dma_act_o(rxa),
    .rx_dma_pause_o(rxdp), .rx_ch_pause_o(rxcp), .tx_flush_o(txf),
    .rx_flush_o(rxf), .tx_fifo_empty_o(txe), .tx_fifo_full_o(txfl),
    .rx_fifo_empty_o(rxe), .rx_fifo_full_o(rxfl), .lr_phase_o(lro),
    .err_sync_o(esync), .err_mode_o(emode)
  );

  // op: 0 tx start, 1 tx stop, 2 rx start, 3 rx stop, 4 mode write
  // exp: {mode[2:0], port, txa, txdp, txcp, rxa, rxdp, rxcp}
  localparam logic [15:0] VEC [13] = '{
    {3'd0, 3'd0, 10'b001_1_100_011},  // R2 off->tx
    {3'd2, 3'd0, 10'b011_1_100_100},  // R4 tx->dup
    {3'd1, 3'd0, 10'b010_1_011_100},  // R3 dup->rx
    {3'd0, 3'd0, 10'b011_1_100_100},  // R2 rx->dup
    {3'd3, 3'd0, 10'b001_1_100_011},  // R5 dup->tx
    {3'd1, 3'd0, 10'b000_0_011_011},  // R3 tx->off
    {3'd2, 3'd0, 10'b010_1_011_100},  // R4 off->rx
    {3'd3, 3'd0, 10'b000_0_011_011},  // R5 rx->off
    {3'd1, 3'd0, 10'b000_0_011_011},  // R3 stop from off
    {3'd4, 3'd3, 10'b011_0_011_011},  // R8 valid write
    {3'd4, 3'd5, 10'b011_0_011_011},  // R8 illegal write
    {3'd3, 3'd0, 10'b001_0_011_011},  // R5 dup->tx, idle
    {3'd2, 3'd0, 10'b011_1_011_100}   // R4 tx->dup
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [9:0] snap();
    return {mode, port_act, txa, txdp, txcp, rxa, rxdp, rxcp};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R1 state", {22'd0, snap()}, {22'd0, 10'b000_0_011_011});
    chk("R1 flags", {28'd0, esync, emode, txf, rxf}, 32'd0);
    rst_n = 1'b1;
    cyc(2);

    for (int i = 0; i < 13; i++) begin
      logic [2:0] op;
      op = VEC[i][15:13];
      case (op)
        3'd0: tx_start = 1'b1;
        3'd1: tx_stop  = 1'b1;
        3'd2: rx_start = 1'b1;
        3'd3: rx_stop  = 1'b1;
        default: begin mwr = 1'b1; mwd = VEC[i][12:10]; end
      endcase
      cyc(1);
      {tx_start, tx_stop, rx_start, rx_stop, mwr} = '0;
      cyc(4);
      chk($sformatf("R2-5/R8 vec%0d", i), {22'd0, snap()}, {22'd0, VEC[i][9:0]});
    end
    chk("R8 sticky err_mode", {31'd0, emode}, 32'd1);

    // R6: flush in cycle after start edge, commit two edges later
    tx_start = 1'b1;
    cyc(1);
    tx_start = 1'b0;
    chk("R6 flush high", {31'd0, txf}, 32'd1);
    chk("R6 not yet active", {31'd0, txa}, 32'd0);
    cyc(1);
    chk("R6 flush one cycle", {31'd0, txf}, 32'd0);
    chk("R6 not yet active", {31'd0, txa}, 32'd0);
    cyc(1);
    chk("R6 committed", {31'd0, txa}, 32'd1);

    // R3: stop acts next edge, no flush
    tx_stop = 1'b1;
    cyc(1);
    tx_stop = 1'b0;
    chk("R3 stop no flush", {30'd0, txf, txa}, 32'd0);
    chk("R3 dup->rx", {29'd0, mode}, 32'd2);

    // R9: same-cycle start and stop on rx
    rx_start = 1'b1; rx_stop = 1'b1;
    cyc(1);
    {rx_start, rx_stop} = '0;
    chk("R9 stop wins", {30'd0, rxf, rxa}, 32'd0);
    cyc(4);
    chk("R9 no late commit", {26'd0, mode, port_act, rxa, rxf}, 32'd0);

    // R7: slave waits for phase
    slave = 1'b1; lr = 1'b0;
    tx_start = 1'b1;
    cyc(1);
    tx_start = 1'b0;
    cyc(4);
    chk("R7 waits for phase", {31'd0, txa}, 32'd0);
    lr = 1'b1;
    cyc(1);
    chk("R7 commit on phase", {31'd0, txa}, 32'd1);
    chk("R7 no error", {31'd0, esync}, 32'd0);
    lr = 1'b0;
    tx_stop = 1'b1;
    cyc(1);
    tx_stop = 1'b0;

    // R9: stop cancels pending start
    tx_start = 1'b1;
    cyc(1);
    tx_start = 1'b0;
    cyc(2);
    tx_stop = 1'b1;
    cyc(1);
    tx_stop = 1'b0;
    lr = 1'b1;
    cyc(4);
    chk("R9 pending start cancelled", {31'd0, txa}, 32'd0);
    lr = 1'b0;

    // R7: timeout
    tx_start = 1'b1;
    cyc(1);
    tx_start = 1'b0;
    cyc(15);
    chk("R7 timeout error", {31'd0, esync}, 32'd1);
    chk("R7 timeout no commit", {31'd0, txa}, 32'd0);
    lr = 1'b1;
    cyc(3);
    chk("R7 no commit after timeout", {31'd0, txa}, 32'd0);
    chk("R7 error sticky", {31'd0, esync}, 32'd1);

    // R10: status
    tx_lvl = '0; rx_lvl = LW'(5); lr = 1'b1;
    cyc(1);
    chk("R10 tx empty", {30'd0, txe, txfl}, 32'd2);
    chk("R10 rx mid", {30'd0, rxe, rxfl}, 32'd0);
    chk("R10 phase high", {31'd0, lro}, 32'd1);
    tx_lvl = LW'(DEPTH); rx_lvl = '0; lr = 1'b0;
    cyc(1);
    chk("R10 tx full", {30'd0, txe, txfl}, 32'd1);
    chk("R10 rx empty", {30'd0, rxe, rxfl}, 32'd2);
    chk("R10 phase low", {31'd0, lro}, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule